// File: doc/BRIEF.md
# Multi-Core External Interrupt Router

This block collects a vector of level-sensitive interrupt lines and sends each one to a single core and to one of that core's four interrupt pins. Every source has an enable bit. Every source has a core-select byte. Each group of 32 sources shares one pin-select byte. Each core has a bank of in-service bits, and software clears these by writing 1. A pin is the OR of all in-service sources that are currently steered to it.

Software programs the router through a plain 32-bit register port. Writes complete in one cycle. Read data appears one cycle after the read strobe, and the port has no back-pressure. Each access also carries the ID of the requesting core, which selects the in-service bank. The interrupt inputs and the per-pin outputs are plain level signals, with no handshake. Changes to an enable bit or to a core or pin selection act at once on interrupts that are already pending.

Top module: `xirq_router`

## Requirements
- R1: After reset, all stored registers and all in-service and pending state are zero, `irq_out` is zero, and reads of the enable and core-select registers return zero. All sources therefore target core 0, pin 0.
- R2: A select byte is decoded as the index of its lowest set bit. A zero byte, or a lowest set bit at position 4 or above, selects index 0. Byte b of core-select register k belongs to source 4k+b. Byte g of the pin-select register belongs to source group g, which holds sources 32g to 32g+31.
- R3: When an input rises, its pending state is always recorded. If its enable bit is set, the source is put in service on its selected core, and `irq_out[core*4+pin]` is high in the next cycle. If its enable bit is clear, the outputs do not change.
- R4: A pin stays high while at least one in-service source is steered to it. It falls only after the last such source has left service.
- R5: When an input falls, its pending state and its in-service bit on every core are cleared, and the output reflects this in the next cycle.
- R6: Writing an enable word puts each newly set bit whose source is pending into service on its selected core. It takes each newly cleared bit whose source is pending out of service.
- R7: The in-service bank that is read or written is the bank of the requesting core (`reg_core`). Writing 1 clears a bit, and writing 0 has no effect. A source whose input stays high is not raised again after it has been cleared.
- R8: When a source's decoded core changes while the source is pending, the source leaves service on the old core. It enters service on the new core if it is enabled. If the source is not pending, only the stored mapping changes.
- R9: When a pin-select byte is written, the outputs of all in-service sources in that group move to the new pin in the next cycle.
- R10: The register map uses only `reg_addr[15:0]`, with word index `addr[7:2]`. The enable words are at 0x0100+4w (w<2). The pin-select register is at 0x0200. The core-select registers are at 0x0300+4k (k<16). The in-service words are at 0x0400+4w. Every other address is unmapped: a read there returns 0 one cycle after the strobe, and a write there changes nothing.
- R11: The node-type words at 0x0500+4i (i<4) and the steering words at 0x0600+4w store and return what was written. They have no effect on `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level interrupt inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 32 | Register byte address; only bits 15:0 are decoded |
| reg_wdata | input | 32 | Write data |
| reg_core | input | 2 | Requesting core ID; selects the in-service bank |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 16 | Per-core pin outputs, bit core*4+pin |

## Verification
A stale or misrouted in-service bit shows up in the cycle after the event that caused it. It appears as a pin that is high on the wrong core or the wrong pin, a pin that fails to drop when its last source leaves, or a cleared source that returns. The bench checks all sixteen pins against a reference model after every input toggle, enable write, select write and clear write, both in a walked table and in a long pseudo-random run. Faults that are hidden at the pins, such as a cleared bit left in the wrong bank, are exposed by reading each core's in-service bank back through the register port.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int unsigned SRC_PER_WORD = 32;
  localparam int unsigned SEL_PER_REG  = 4;
  localparam int unsigned NODE_REGS    = 4;

  // Address region codes in reg_addr[15:8]
  localparam logic [7:0] RGN_ENABLE = 8'h01;
  localparam logic [7:0] RGN_PINSEL = 8'h02;
  localparam logic [7:0] RGN_CORSEL = 8'h03;
  localparam logic [7:0] RGN_INSVC  = 8'h04;
  localparam logic [7:0] RGN_NODE   = 8'h05;
  localparam logic [7:0] RGN_STEER  = 8'h06;

  // Lowest set bit below n_tgt wins; none in range selects 0
  function automatic int unsigned pick_target(input logic [7:0] sel_byte,
                                              input int unsigned n_tgt);
    int unsigned res;
    res = 0;
    for (int i = 7; i >= 0; i--) begin
      if ((i < int'(n_tgt)) && sel_byte[i]) res = unsigned'(i);
    end
    return res;
  endfunction

endpackage

// File: rtl/xirq_regfile.sv
module xirq_regfile
  import xirq_pkg::*;
#(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned NCORE = 4,
  parameter int unsigned NPIN  = 4,
  localparam int unsigned CW   = $clog2(NCORE),
  localparam int unsigned PW   = $clog2(NPIN),
  localparam int unsigned NWORD = NSRC / SRC_PER_WORD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [31:0]                  reg_addr,
  input  logic [31:0]                  reg_wdata,
  input  logic [CW-1:0]                reg_core,
  input  logic [NCORE-1:0][NSRC-1:0]   isr_i,
  output logic [31:0]                  reg_rdata,
  output logic [NSRC-1:0]              en_q_o,
  output logic [NSRC-1:0]              en_d_o,
  output logic [NSRC*CW-1:0]           core_q_o,
  output logic [NSRC*CW-1:0]           core_d_o,
  output logic [NWORD*PW-1:0]          pin_sel_o,
  output logic [NSRC-1:0]              w1c_clr_o,
  output logic [CW-1:0]                w1c_core_o
);

  localparam int unsigned NCSEL = NSRC / SEL_PER_REG;
  localparam int unsigned NPSEL = (NWORD + SEL_PER_REG - 1) / SEL_PER_REG;

  logic [31:0] en_q    [NWORD];
  logic [31:0] csel_q  [NCSEL];
  logic [31:0] psel_q  [NPSEL];
  logic [31:0] node_q  [NODE_REGS];
  logic [31:0] steer_q [NWORD];
  logic [31:0] csel_d  [NCSEL];
  logic [31:0] rd_mux;
  logic [31:0] rdata_q;

  logic [7:0]  rgn;
  logic [31:0] idx;
  logic        hit_en, hit_ps, hit_cs, hit_is, hit_nd, hit_st, hit_any;
  logic        addr_unused;

  assign rgn         = reg_addr[15:8];
  assign idx         = 32'(reg_addr[7:2]);
  assign addr_unused = ^{reg_addr[31:16], reg_addr[1:0]};

  assign hit_en  = (rgn == RGN_ENABLE) && (idx < NWORD);
  assign hit_ps  = (rgn == RGN_PINSEL) && (idx < NPSEL);
  assign hit_cs  = (rgn == RGN_CORSEL) && (idx < NCSEL);
  assign hit_is  = (rgn == RGN_INSVC)  && (idx < NWORD);
  assign hit_nd  = (rgn == RGN_NODE)   && (idx < NODE_REGS);
  assign hit_st  = (rgn == RGN_STEER)  && (idx < NWORD);
  assign hit_any = hit_en | hit_ps | hit_cs | hit_is | hit_nd | hit_st;

  // Next-cycle enables and clear masks, visible to the service logic
  always_comb begin
    for (int w = 0; w < int'(NWORD); w++) begin
      en_q_o[w*32 +: 32]    = en_q[w];
      en_d_o[w*32 +: 32]    = (reg_wr && hit_en && idx == 32'(w)) ? reg_wdata : en_q[w];
      w1c_clr_o[w*32 +: 32] = (reg_wr && hit_is && idx == 32'(w)) ? reg_wdata : 32'h0;
    end
    for (int k = 0; k < int'(NCSEL); k++) begin
      csel_d[k] = (reg_wr && hit_cs && idx == 32'(k)) ? reg_wdata : csel_q[k];
    end
  end

  assign w1c_core_o = reg_core;

  // Select-byte decode, current and next
  always_comb begin
    for (int n = 0; n < int'(NSRC); n++) begin
      core_q_o[n*CW +: CW] = CW'(pick_target(csel_q[n/4][(n%4)*8 +: 8], NCORE));
      core_d_o[n*CW +: CW] = CW'(pick_target(csel_d[n/4][(n%4)*8 +: 8], NCORE));
    end
    for (int g = 0; g < int'(NWORD); g++) begin
      pin_sel_o[g*PW +: PW] = PW'(pick_target(psel_q[g/4][(g%4)*8 +: 8], NPIN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(NWORD); w++) begin
        en_q[w]    <= '0;
        steer_q[w] <= '0;
      end
      for (int k = 0; k < int'(NCSEL); k++) csel_q[k] <= '0;
      for (int k = 0; k < int'(NPSEL); k++) psel_q[k] <= '0;
      for (int k = 0; k < int'(NODE_REGS); k++) node_q[k] <= '0;
    end else begin
      for (int w = 0; w < int'(NWORD); w++) begin
        en_q[w] <= en_d_o[w*32 +: 32];
        if (reg_wr && hit_st && idx == 32'(w)) steer_q[w] <= reg_wdata;
      end
      for (int k = 0; k < int'(NCSEL); k++) csel_q[k] <= csel_d[k];
      for (int k = 0; k < int'(NPSEL); k++) begin
        if (reg_wr && hit_ps && idx == 32'(k)) psel_q[k] <= reg_wdata;
      end
      for (int k = 0; k < int'(NODE_REGS); k++) begin
        if (reg_wr && hit_nd && idx == 32'(k)) node_q[k] <= reg_wdata;
      end
    end
  end

  // Readback returns stored state from before any same-cycle write
  always_comb begin
    rd_mux = 32'h0;
    for (int w = 0; w < int'(NWORD); w++) begin
      if (hit_en && idx == 32'(w)) rd_mux = en_q[w];
      if (hit_is && idx == 32'(w)) rd_mux = isr_i[reg_core][w*32 +: 32];
      if (hit_st && idx == 32'(w)) rd_mux = steer_q[w];
    end
    for (int k = 0; k < int'(NCSEL); k++) if (hit_cs && idx == 32'(k)) rd_mux = csel_q[k];
    for (int k = 0; k < int'(NPSEL); k++) if (hit_ps && idx == 32'(k)) rd_mux = psel_q[k];
    for (int k = 0; k < int'(NODE_REGS); k++) if (hit_nd && idx == 32'(k)) rd_mux = node_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hit_any) |=> (reg_rdata == 32'h0));

endmodule

// File: rtl/xirq_service.sv
module xirq_service
#(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned NCORE = 4,
  localparam int unsigned CW   = $clog2(NCORE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             irq_in,
  input  logic [NSRC-1:0]             en_q,
  input  logic [NSRC-1:0]             en_d,
  input  logic [NSRC*CW-1:0]          core_q,
  input  logic [NSRC*CW-1:0]          core_d,
  input  logic [NSRC-1:0]             w1c_clr,
  input  logic [CW-1:0]               w1c_core,
  output logic [NCORE-1:0][NSRC-1:0]  isr_o
);

  logic [NSRC-1:0]            raw_q;
  logic [NCORE-1:0][NSRC-1:0] isr_q, isr_d;
  logic [CW-1:0]              cq_a [NSRC];
  logic [CW-1:0]              cd_a [NSRC];
  logic [NSRC-1:0]            rise, en_up, en_dn, move;
  logic [NSRC-1:0]            isr_any;

  for (genvar gn = 0; gn < NSRC; gn++) begin : g_sel
    assign cq_a[gn] = core_q[gn*CW +: CW];
    assign cd_a[gn] = core_d[gn*CW +: CW];
    assign move[gn] = (core_q[gn*CW +: CW] != core_d[gn*CW +: CW]);
  end

  assign rise  = irq_in & ~raw_q;
  assign en_up = en_d & ~en_q;
  assign en_dn = en_q & ~en_d;

  // Clears first, then sets: a fresh raise wins over a same-cycle clear
  always_comb begin
    isr_d = isr_q;
    for (int n = 0; n < int'(NSRC); n++) begin
      if (!irq_in[n] || en_dn[n]) begin
        for (int c = 0; c < int'(NCORE); c++) isr_d[c][n] = 1'b0;
      end
      if (move[n])    isr_d[cq_a[n]][n] = 1'b0;
      if (w1c_clr[n]) isr_d[w1c_core][n] = 1'b0;
      if (irq_in[n] && en_d[n] && (rise[n] || en_up[n] || move[n]))
        isr_d[cd_a[n]][n] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      isr_q <= '0;
    end else begin
      raw_q <= irq_in;
      isr_q <= isr_d;
    end
  end

  assign isr_o = isr_q;

  always_comb begin
    isr_any = '0;
    for (int c = 0; c < int'(NCORE); c++) isr_any = isr_any | isr_q[c];
  end

  assert_rise_enters_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_in & ~raw_q & en_d) & ~isr_any) == '0));

  assert_service_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_any & ~raw_q) == '0));

  assert_service_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_any & ~en_q) == '0));

  for (genvar gs = 0; gs < NSRC; gs++) begin : g_chk
    logic [NCORE-1:0] col;
    always_comb begin
      for (int c = 0; c < int'(NCORE); c++) col[c] = isr_q[c][gs];
    end
    assert_single_core_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

endmodule

// File: rtl/xirq_pinmux.sv
module xirq_pinmux
#(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned NCORE = 4,
  parameter int unsigned NPIN  = 4,
  localparam int unsigned PW   = $clog2(NPIN),
  localparam int unsigned NWORD = NSRC / 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCORE-1:0][NSRC-1:0]  isr_i,
  input  logic [NWORD*PW-1:0]         pin_sel,
  output logic [NCORE*NPIN-1:0]       irq_out
);

  logic [NPIN-1:0][NSRC-1:0] grp_mask;

  for (genvar gp = 0; gp < NPIN; gp++) begin : g_mask
    for (genvar gn = 0; gn < NSRC; gn++) begin : g_src
      assign grp_mask[gp][gn] = (pin_sel[(gn/32)*PW +: PW] == PW'(gp));
    end
  end

  for (genvar gc = 0; gc < NCORE; gc++) begin : g_core
    for (genvar gp = 0; gp < NPIN; gp++) begin : g_pin
      assign irq_out[gc*NPIN + gp] = |(isr_i[gc] & grp_mask[gp]);
    end
    assert_pin_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|irq_out[gc*NPIN +: NPIN]) == (|isr_i[gc])));
  end

endmodule

// File: rtl/xirq_router.sv
module xirq_router
#(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned NCORE = 4,
  parameter int unsigned NPIN  = 4,
  localparam int unsigned CW   = $clog2(NCORE),
  localparam int unsigned PW   = $clog2(NPIN),
  localparam int unsigned NWORD = NSRC / 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         irq_in,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [31:0]             reg_addr,
  input  logic [31:0]             reg_wdata,
  input  logic [CW-1:0]           reg_core,
  output logic [31:0]             reg_rdata,
  output logic [NCORE*NPIN-1:0]   irq_out
);

  logic [NSRC-1:0]            en_q, en_d, w1c_clr;
  logic [NSRC*CW-1:0]         core_q, core_d;
  logic [NWORD*PW-1:0]        pin_sel;
  logic [CW-1:0]              w1c_core;
  logic [NCORE-1:0][NSRC-1:0] isr;

  xirq_regfile #(.NSRC(NSRC), .NCORE(NCORE), .NPIN(NPIN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_core   (reg_core),
    .isr_i      (isr),
    .reg_rdata  (reg_rdata),
    .en_q_o     (en_q),
    .en_d_o     (en_d),
    .core_q_o   (core_q),
    .core_d_o   (core_d),
    .pin_sel_o  (pin_sel),
    .w1c_clr_o  (w1c_clr),
    .w1c_core_o (w1c_core)
  );

  xirq_service #(.NSRC(NSRC), .NCORE(NCORE)) u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .en_q     (en_q),
    .en_d     (en_d),
    .core_q   (core_q),
    .core_d   (core_d),
    .w1c_clr  (w1c_clr),
    .w1c_core (w1c_core),
    .isr_o    (isr)
  );

  xirq_pinmux #(.NSRC(NSRC), .NCORE(NCORE), .NPIN(NPIN)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .isr_i   (isr),
    .pin_sel (pin_sel),
    .irq_out (irq_out)
  );

endmodule

// File: tb/xirq_router_bench.sv
module xirq_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_core = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xirq_router u_xirq_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_core(reg_core),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Reference state
  logic [63:0] m_raw, m_en;
  logic [63:0] m_isr  [4];
  logic [31:0] m_csel [16];
  logic [31:0] m_psel;
  logic [31:0] m_node [4];
  logic [31:0] m_steer[2];

  function automatic int dec(input logic [7:0] b);
    for (int i = 0; i < 4; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic int mcore(input int n);
    return dec(m_csel[n/4][(n%4)*8 +: 8]);
  endfunction

  function automatic int mpin(input int n);
    return dec(m_psel[(n/32)*8 +: 8]);
  endfunction

  function automatic logic [15:0] exp_pins();
    logic [15:0] e;
    e = '0;
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 64; n++)
        if (m_isr[c][n]) e[c*4 + mpin(n)] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] addr, input logic [1:0] req);
    logic [7:0] rgn;
    int idx;
    rgn = addr[15:8];
    idx = int'(addr[7:2]);
    case (rgn)
      8'h01: if (idx < 2)  return m_en[idx*32 +: 32];
      8'h02: if (idx == 0) return m_psel;
      8'h03: if (idx < 16) return m_csel[idx];
      8'h04: if (idx < 2)  return m_isr[req][idx*32 +: 32];
      8'h05: if (idx < 4)  return m_node[idx];
      8'h06: if (idx < 2)  return m_steer[idx];
      default: ;
    endcase
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    chk(tag, {16'h0, irq_out}, {16'h0, exp_pins()});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    m_raw = '0; m_en = '0; m_psel = '0;
    for (int c = 0; c < 4; c++) m_isr[c] = '0;
    for (int k = 0; k < 16; k++) m_csel[k] = '0;
    for (int k = 0; k < 4; k++) m_node[k] = '0;
    for (int k = 0; k < 2; k++) m_steer[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_inputs(input logic [63:0] v, input string tag);
    irq_in = v;
    for (int n = 0; n < 64; n++) begin
      if (v[n] && !m_raw[n]) begin
        m_raw[n] = 1'b1;
        if (m_en[n]) m_isr[mcore(n)][n] = 1'b1;
      end else if (!v[n] && m_raw[n]) begin
        m_raw[n] = 1'b0;
        for (int c = 0; c < 4; c++) m_isr[c][n] = 1'b0;
      end
    end
    @(negedge clk);
    check_pins(tag);
  endtask

  task automatic do_write(input logic [31:0] addr, input logic [31:0] data,
                          input logic [1:0] req, input string tag);
    logic [7:0]  rgn;
    logic [31:0] old;
    int idx;
    int oc [4];
    rgn = addr[15:8];
    idx = int'(addr[7:2]);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data; reg_core = req;
    case (rgn)
      8'h01: if (idx < 2) begin
        old = m_en[idx*32 +: 32];
        m_en[idx*32 +: 32] = data;
        for (int b = 0; b < 32; b++) begin
          if (m_raw[idx*32+b] && data[b] && !old[b]) m_isr[mcore(idx*32+b)][idx*32+b] = 1'b1;
          if (m_raw[idx*32+b] && !data[b] && old[b])
            for (int c = 0; c < 4; c++) m_isr[c][idx*32+b] = 1'b0;
        end
      end
      8'h02: if (idx == 0) m_psel = data;
      8'h03: if (idx < 16) begin
        for (int b = 0; b < 4; b++) oc[b] = mcore(idx*4+b);
        m_csel[idx] = data;
        for (int b = 0; b < 4; b++) begin
          if (mcore(idx*4+b) != oc[b] && m_raw[idx*4+b]) begin
            m_isr[oc[b]][idx*4+b] = 1'b0;
            if (m_en[idx*4+b]) m_isr[mcore(idx*4+b)][idx*4+b] = 1'b1;
          end
        end
      end
      8'h04: if (idx < 2) m_isr[req][idx*32 +: 32] = m_isr[req][idx*32 +: 32] & ~data;
      8'h05: if (idx < 4) m_node[idx] = data;
      8'h06: if (idx < 2) m_steer[idx] = data;
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
    check_pins(tag);
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [1:0] req,
                         input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = addr; reg_core = req;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic expect_pins(input logic [15:0] exp, input string tag);
    chk(tag, {16'h0, irq_out}, {16'h0, exp});
  endtask

  // {kind(0 inputs,1 write), core, addr, data}
  localparam int NSTEP = 16;
  localparam logic [83:0] STEPS [NSTEP] = '{
    {2'd1, 2'd0, 16'h0100, 64'h0000_0000_0000_00FF},
    {2'd0, 2'd0, 16'h0000, 64'h0000_0000_0000_0003},
    {2'd1, 2'd0, 16'h0300, 64'h0000_0000_0000_0402},
    {2'd1, 2'd0, 16'h0200, 64'h0000_0000_0000_0008},
    {2'd0, 2'd0, 16'h0000, 64'h0000_0100_0000_0003},
    {2'd1, 2'd0, 16'h0104, 64'h0000_0000_0000_0100},
    {2'd1, 2'd1, 16'h0400, 64'h0000_0000_0000_0001},
    {2'd1, 2'd2, 16'h0400, 64'h0000_0000_0000_0000},
    {2'd1, 2'd0, 16'h0400, 64'h0000_0000_0000_0002},
    {2'd1, 2'd0, 16'h0100, 64'h0000_0000_0000_0000},
    {2'd1, 2'd0, 16'h0100, 64'h0000_0000_0000_00FF},
    {2'd1, 2'd0, 16'h0328, 64'h0000_0000_0000_0018},
    {2'd0, 2'd0, 16'h0000, 64'h0000_0100_0000_0000},
    {2'd1, 2'd0, 16'h0200, 64'h0000_0000_0000_0200},
    {2'd0, 2'd0, 16'h0000, 64'h0000_0100_0000_0020},
    {2'd0, 2'd0, 16'h0000, 64'h0000_0000_0000_0000}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [31:0] r;
    do_reset();
    @(negedge clk);
    expect_pins(16'h0, "R1 reset outputs");
    do_read(32'h0100, 2'd0, 32'h0, "R1 reset enable");
    do_read(32'h0300, 2'd0, 32'h0, "R1 reset core select");

    // Table walk: R3/R6/R7/R8/R9 against the reference after each step
    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i][83:82] == 2'd0) do_inputs(STEPS[i][63:0], "R3/R5 table input");
      else do_write({16'h0, STEPS[i][79:64]}, STEPS[i][31:0], STEPS[i][81:80], "R6/R7/R8/R9 table write");
    end

    // Pseudo-random run
    s = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      r = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      case (r % 7)
        0, 1: do_inputs(irq_in ^ (64'h1 << (s % 64)), "R3/R5 random toggle");
        2: do_write(32'h0100 + 4*(s & 1), r ^ s, 2'd0, "R6 random enable");
        3: do_write(32'h0300 + 4*(s % 16), s, 2'd0, "R8 random core select");
        4: do_write(32'h0400 + 4*(s & 1), s, r[9:8], "R7 random clear");
        5: do_write(32'h0200, s, 2'd0, "R9 random pin select");
        default: do_read(32'h0400 + 4*(s & 1), r[5:4], model_read(32'h0400 + 4*(s & 1), r[5:4]),
                         "R7 random bank read");
      endcase
    end

    // Directed corner cases
    do_reset();
    do_write(32'h0100, 32'h1, 2'd0, "R6 enable src0");
    do_write(32'h0300, 32'hF0, 2'd0, "R2 high bit falls back");
    do_inputs(64'h1, "R3 rise");
    expect_pins(16'h0001, "R2 fallback core0 pin0");
    do_write(32'h0300, 32'h0C, 2'd0, "R8 move");
    expect_pins(16'h0100, "R8 moved to core2");
    do_write(32'h0200, 32'h06, 2'd0, "R9 pin move");
    expect_pins(16'h0200, "R9 moved to pin1");
    do_write(32'h0200, 32'h50, 2'd0, "R2 pin fallback");
    expect_pins(16'h0100, "R2 pin fallback pin0");
    do_read(32'h0400, 2'd2, 32'h1, "R7 bank core2");
    do_read(32'h0400, 2'd0, 32'h0, "R7 bank core0");
    do_write(32'h0400, 32'h1, 2'd0, "R7 other bank");
    expect_pins(16'h0100, "R7 other bank no effect");
    do_write(32'h0400, 32'h0, 2'd2, "R7 zero write");
    expect_pins(16'h0100, "R7 zero write no effect");
    do_write(32'h0400, 32'h1, 2'd2, "R7 clear");
    expect_pins(16'h0000, "R7 cleared");
    @(negedge clk);
    expect_pins(16'h0000, "R7 held input not raised again");
    do_write(32'h0100, 32'h0, 2'd0, "R6 disable");
    do_write(32'h0100, 32'h1, 2'd0, "R6 re-enable");
    expect_pins(16'h0100, "R6 re-enable raises pending");
    do_inputs(64'h0, "R5 fall");
    expect_pins(16'h0000, "R5 fall drops pin");
    do_read(32'h0400, 2'd2, 32'h0, "R5 in-service cleared");
    do_write(32'h0100, 32'h0, 2'd0, "R3 disable");
    do_inputs(64'h2, "R3 disabled rise");
    expect_pins(16'h0000, "R3 disabled no output");
    do_write(32'h0300, 32'h0000_080C, 2'd0, "R8 move while disabled");
    expect_pins(16'h0000, "R8 disabled move no raise");
    do_write(32'h0100, 32'h2, 2'd0, "R6 enable pending src1");
    expect_pins(16'h1000, "R6 raised on core3 pin0");
    do_write(32'h0300, 32'h0008_080C, 2'd0, "R4 map src2");
    do_write(32'h0100, 32'h6, 2'd0, "R4 enable src2");
    do_inputs(64'h6, "R4 second source");
    expect_pins(16'h1000, "R4 two sources one pin");
    do_inputs(64'h4, "R4 one source left");
    expect_pins(16'h1000, "R4 pin held by last source");
    do_inputs(64'h0, "R4 last source gone");
    expect_pins(16'h0000, "R4 pin drops after last");
    do_read(32'h0700, 2'd0, 32'h0, "R10 unmapped read");
    do_read(32'h0108, 2'd0, 32'h0, "R10 out-of-range enable read");
    do_write(32'h0700, 32'hFFFF_FFFF, 2'd0, "R10 unmapped write");
    do_read(32'h0100, 2'd0, 32'h6, "R10 enable unchanged");
    do_write(32'hABCD_0104, 32'h1, 2'd0, "R10 upper address bits ignored");
    do_read(32'h0104, 2'd0, 32'h1, "R10 aliased write landed");
    do_read(32'h0300, 2'd0, 32'h0008_080C, "R10 core select readback");
    do_write(32'h0508, 32'hDEAD_BEEF, 2'd0, "R11 node write");
    do_write(32'h0604, 32'h1234_5678, 2'd0, "R11 steer write");
    expect_pins(16'h0000, "R11 storage no output effect");
    do_read(32'h0508, 2'd0, 32'hDEAD_BEEF, "R11 node readback");
    do_read(32'h0604, 2'd0, 32'h1234_5678, "R11 steer readback");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule